// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives an external analog-to-digital converter through a sequence of channels, from channel 0 up to a programmed last channel. It runs one pass per start command or loops without end. Each 10-bit result lands in that channel's own pair of byte-wide buffer registers. Software reads the pair in either right-aligned or left-aligned layout. When the last channel of a pass has been stored, an end-of-pass flag is raised, and it can drive an interrupt line.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational on the address. The converter side uses a valid/ready request that carries a channel number. The request is held stable until the converter raises ready, which provides back-pressure. The converter returns one result strobe for each accepted request. Only one request is ever outstanding, so the result strobe needs no ready. A strobe that arrives when no request is pending is ignored. Powering up the converter takes one write of the power bit, and starting conversions takes a second write.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, every register and buffer reads 0, no converter request is raised, and the interrupt is low.
- R2: Writing 1 to the power bit (address 0x01 bit 0) while it holds 0 only wakes the block and issues no request. Writing 1 to it again while it holds 1 and the sequencer is idle starts a pass.
- R3: With scan enabled (address 0x02 bit 1), a pass requests channels 0, 1, ... up to the last channel in order. A request stays valid with a stable channel until ready. The next request comes only after the result strobe of the previous one.
- R4: Each result is stored in its own channel's buffer. The high byte is at address 0x10+2c and the low byte is at 0x11+2c for channel c.
- R5: With address 0x02 bit 3 set (right-aligned), the high byte reads {6'b0,r[9:8]} and the low byte reads r[7:0]. With it clear, the high byte reads r[9:2] and the low byte reads {r[1:0],6'b0}. The layout applies when the buffer is read.
- R6: The flag (address 0x00 bit 7) sets once the last channel of a pass is stored. The interrupt output equals the flag ANDed with the enable at address 0x00 bit 5.
- R7: A write to address 0x00 with bit 7 = 0 clears the flag, and a write with bit 7 = 1 leaves it unchanged. If the flag is set in the same cycle as such a clear, it ends up set.
- R8: Every write to address 0x00 reloads the last-channel field (bits 3:0), including during a pass. A pass ends at the first stored channel that is at or above the current field value.
- R9: With the continuous bit (address 0x01 bit 1) set, the sequence restarts at channel 0 after the last channel. With it clear, the sequencer goes idle after the pass and issues no request until a new start.
- R10: With scan disabled, a pass converts only the channel named by the last-channel field.
- R11: A last-channel value above N_CH-1 acts as N_CH-1, so no request names a channel at or above N_CH.
- R12: Writing 0 to the power bit aborts any pass and drops the request at once. The next write of 1 only wakes the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (0 for unmapped addresses) |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts the request |
| conv_req_ch | output | 4 | Channel number of the request |
| conv_res_valid | input | 1 | Result strobe for the accepted request |
| conv_res_data | input | 10 | Conversion result |
| eoc_irq | output | 1 | End-of-pass interrupt |

## Verification
The bench builds the block with its defaults, N_CH = 10 and ADDR_W = 6. With these values the 4-bit last-channel field can hold 10 to 15, which exercises the clamp, and all twenty buffer addresses fit below the top of the address range. A converter model accepts requests after random stalls and answers after random latencies, so the hold-until-ready and single-outstanding rules are exercised. A held result strobe lets a flag set land in the same cycle as a software clear. A mid-pass rewrite of the last channel and a mid-pass power-down check the ordering cases.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_W  = 4;
  localparam int RES_W = 10;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  // Byte view of a stored result; lo selects the low byte, ral the right layout
  function automatic logic [7:0] fmt_byte(input logic [RES_W-1:0] r,
                                          input logic lo, input logic ral);
    if (ral) return lo ? r[7:0] : {6'b0, r[9:8]};
    else     return lo ? {r[1:0], 6'b0} : r[9:2];
  endfunction
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int N_CH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr,
  input  logic            cra_wr,
  input  logic            crb_wr,
  input  logic [7:0]      wdata,
  input  logic            pass_done,
  output logic [CH_W-1:0] last_eff,
  output logic            scan_en,
  output logic            cont_en,
  output logic            ralign,
  output logic            pwr_on,
  output logic            start,
  output logic            eoc_irq,
  output logic [7:0]      csr_byte,
  output logic [7:0]      cra_byte,
  output logic [7:0]      crb_byte
);
  localparam logic [CH_W-1:0] MAX_CH = CH_W'(N_CH - 1);

  logic [CH_W-1:0] last_q;
  logic            eoc_q, ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q  <= '0;
      eoc_q   <= 1'b0;
      ie_q    <= 1'b0;
      pwr_on  <= 1'b0;
      cont_en <= 1'b0;
      scan_en <= 1'b0;
      ralign  <= 1'b0;
    end else begin
      if (csr_wr) begin
        last_q <= wdata[3:0];
        ie_q   <= wdata[5];
      end
      if (pass_done)                eoc_q <= 1'b1;
      else if (csr_wr && !wdata[7]) eoc_q <= 1'b0;
      if (cra_wr) begin
        pwr_on  <= wdata[0];
        cont_en <= wdata[1];
      end
      if (crb_wr) begin
        scan_en <= wdata[1];
        ralign  <= wdata[3];
      end
    end
  end

  assign start    = cra_wr && wdata[0] && pwr_on;
  assign last_eff = (last_q > MAX_CH) ? MAX_CH : last_q;
  assign eoc_irq  = eoc_q && ie_q;
  assign csr_byte = {eoc_q, 1'b0, ie_q, 1'b0, last_q};
  assign cra_byte = {6'b0, cont_en, pwr_on};
  assign crb_byte = {4'b0, ralign, 1'b0, scan_en, 1'b0};

  assert_eoc_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_q) |-> $past(pass_done));
  assert_eoc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_q) |-> $past(csr_wr && !wdata[7]));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> eoc_q);
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int N_CH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_on,
  input  logic            start,
  input  logic            scan_en,
  input  logic            cont_en,
  input  logic [CH_W-1:0] last_ch,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [CH_W-1:0] req_ch,
  input  logic            res_valid,
  output logic            store,
  output logic            pass_done
);
  sq_state_e       state;
  logic [CH_W-1:0] cur_ch, first_ch;
  logic            last_hit;

  assign first_ch  = scan_en ? '0 : last_ch;
  assign last_hit  = !scan_en || (cur_ch >= last_ch);
  assign req_valid = pwr_on && (state == SQ_REQ);
  assign req_ch    = cur_ch;
  assign store     = pwr_on && (state == SQ_WAIT) && res_valid;
  assign pass_done = store && last_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cur_ch <= '0;
    end else if (!pwr_on) begin
      state  <= SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_REQ;
          cur_ch <= first_ch;
        end
        SQ_REQ: if (req_ready) state <= SQ_WAIT;
        SQ_WAIT: if (res_valid) begin
          if (!last_hit) begin
            cur_ch <= cur_ch + 1'b1;
            state  <= SQ_REQ;
          end else if (cont_en) begin
            cur_ch <= first_ch;
            state  <= SQ_REQ;
          end else begin
            state  <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && pwr_on) |=> (req_valid && $stable(req_ch)));
  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
  assert_req_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_ch < CH_W'(N_CH)));
  assert_pwr_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> !req_valid);
endmodule

// File: rtl/adc_scan_buf.sv
module adc_scan_buf
  import adc_scan_pkg::*;
#(
  parameter int N_CH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [CH_W-1:0]  rd_ch,
  input  logic             rd_lo,
  input  logic             ralign,
  output logic [7:0]       rd_byte
);
  logic [RES_W-1:0] slot [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot[g] <= '0;
      else if (store && (wr_ch == CH_W'(g)))       slot[g] <= wr_data;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (rd_en && (rd_ch < CH_W'(N_CH)))
      rd_byte = fmt_byte(slot[rd_ch], rd_lo, ralign);
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int N_CH   = 10,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [3:0]        conv_req_ch,
  input  logic              conv_res_valid,
  input  logic [9:0]        conv_res_data,
  output logic              eoc_irq
);
  localparam logic [ADDR_W-1:0] A_CSR   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CRA   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CRB   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BUF   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_BUFE  = ADDR_W'(16 + 2 * N_CH);

  logic            csr_wr, cra_wr, crb_wr;
  logic [CH_W-1:0] last_eff;
  logic            scan_en, cont_en, ralign, pwr_on, start;
  logic            store, pass_done;
  logic [7:0]      csr_byte, cra_byte, crb_byte, buf_byte;
  logic            in_buf;
  logic [ADDR_W-1:0] off;

  assign csr_wr = reg_wr && (reg_addr == A_CSR);
  assign cra_wr = reg_wr && (reg_addr == A_CRA);
  assign crb_wr = reg_wr && (reg_addr == A_CRB);
  assign in_buf = (reg_addr >= A_BUF) && (reg_addr < A_BUFE);
  assign off    = reg_addr - A_BUF;

  adc_scan_regs #(.N_CH(N_CH)) u_regs (
    .clk, .rst_n, .csr_wr, .cra_wr, .crb_wr, .wdata(reg_wdata),
    .pass_done, .last_eff, .scan_en, .cont_en, .ralign, .pwr_on, .start,
    .eoc_irq, .csr_byte, .cra_byte, .crb_byte
  );

  adc_scan_fsm #(.N_CH(N_CH)) u_fsm (
    .clk, .rst_n, .pwr_on, .start, .scan_en, .cont_en, .last_ch(last_eff),
    .req_valid(conv_req_valid), .req_ready(conv_req_ready),
    .req_ch(conv_req_ch), .res_valid(conv_res_valid), .store, .pass_done
  );

  adc_scan_buf #(.N_CH(N_CH)) u_buf (
    .clk, .rst_n, .store, .wr_ch(conv_req_ch), .wr_data(conv_res_data),
    .rd_en(in_buf), .rd_ch(CH_W'(off >> 1)), .rd_lo(off[0]), .ralign,
    .rd_byte(buf_byte)
  );

  always_comb begin
    unique case (1'b1)
      (reg_addr == A_CSR): reg_rdata = csr_byte;
      (reg_addr == A_CRA): reg_rdata = cra_byte;
      (reg_addr == A_CRB): reg_rdata = crb_byte;
      in_buf:              reg_rdata = buf_byte;
      default:             reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
  localparam int NCH = 10;
  localparam int AW  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic conv_req_valid, conv_req_ready = 1'b0;
  logic [3:0] conv_req_ch;
  logic conv_res_valid = 1'b0;
  logic [9:0] conv_res_data = '0;
  logic eoc_irq;

  int n_chk = 0, n_fail = 0;
  int log_q [256];
  int log_n = 0;
  logic [9:0] exp_buf [NCH];
  bit busy = 0, manual = 0, force_fire = 0;
  int pch = 0, cnt = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.N_CH(NCH), .ADDR_W(AW)) i_adc_scan_seq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .conv_req_valid, .conv_req_ready, .conv_req_ch,
    .conv_res_valid, .conv_res_data, .eoc_irq
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Converter model: random stall before ready, random latency to result
  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; conv_req_ready = 0; conv_res_valid = 0;
      for (int i = 0; i < NCH; i++) exp_buf[i] = '0;
    end else begin
      conv_req_ready = 0;
      conv_res_valid = 0;
      if (busy) begin
        if (conv_req_valid) chk(0, "R3 second request while busy", 1, 0);
        if (force_fire || (!manual && cnt == 0)) begin
          conv_res_valid = 1;
          conv_res_data  = 10'($urandom);
          exp_buf[pch]   = conv_res_data;
          busy = 0;
        end else if (cnt > 0) cnt--;
      end else if (conv_req_valid && ($urandom % 2 == 0)) begin
        conv_req_ready = 1;
        if (log_n < 256) log_q[log_n] = int'(conv_req_ch);
        log_n++;
        pch  = int'(conv_req_ch);
        busy = 1;
        cnt  = 4 + int'($urandom % 8);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_byte(input logic [9:0] r, input bit lo, input bit ral);
    logic [15:0] w;
    w = ral ? {6'b0, r} : {r, 6'b0};
    return lo ? w[7:0] : w[15:8];
  endfunction

  task automatic wait_eoc(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(6'h00, d);
      if (d[7]) return;
    end
    chk(0, tag, 0, 1);
  endtask

  task automatic wait_quiet(input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #1 if (conv_req_valid) seen++;
    end
  endtask

  task automatic chk_order(input int first, input int last, input int passes, input string tag);
    int span = last - first + 1;
    chk(log_n == span * passes, tag, log_n, span * passes);
    for (int i = 0; i < log_n && i < 256; i++)
      chk(log_q[i] == first + (i % span), tag, log_q[i], first + (i % span));
  endtask

  task automatic chk_bufs(input int last, input bit ral, input string tag);
    logic [7:0] d;
    for (int c = 0; c <= last; c++) begin
      rd(AW'(16 + 2 * c), d);
      chk(d == exp_byte(exp_buf[c], 0, ral), tag, d, exp_byte(exp_buf[c], 0, ral));
      rd(AW'(17 + 2 * c), d);
      chk(d == exp_byte(exp_buf[c], 1, ral), tag, d, exp_byte(exp_buf[c], 1, ral));
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seen;
    void'($urandom(32'd20240817));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h00, d); chk(d == 0, "R1 status reset", d, 0);
    rd(6'h01, d); chk(d == 0, "R1 ctrl A reset", d, 0);
    rd(6'h02, d); chk(d == 0, "R1 ctrl B reset", d, 0);
    rd(6'h10, d); chk(d == 0, "R1 buffer reset", d, 0);
    chk(!conv_req_valid && !eoc_irq, "R1 outputs reset", conv_req_valid, 0);

    // R2 first power write only wakes
    wr(6'h02, 8'h0A);
    wr(6'h00, 8'h03);
    wr(6'h01, 8'h01);
    wait_quiet(30, seen);
    chk(seen == 0 && log_n == 0, "R2 wake issues no request", seen, 0);
    rd(6'h01, d); chk(d == 8'h01, "R2 power bit reads back", d, 1);
    wr(6'h01, 8'h01);
    wait_eoc("R6 flag after pass");
    chk_order(0, 3, 1, "R3 scan order");
    chk_bufs(3, 1, "R4 R5 right aligned buffers");
    chk(eoc_irq == 0, "R6 irq masked", eoc_irq, 0);
    wait_quiet(40, seen);
    chk(seen == 0, "R9 one-shot returns idle", seen, 0);

    // R6 R7 enable, write 1 keeps flag, write 0 clears
    wr(6'h00, 8'hA3);
    rd(6'h00, d); chk(d == 8'hA3, "R7 write 1 keeps flag", d, 8'hA3);
    chk(eoc_irq == 1, "R6 irq follows flag", eoc_irq, 1);
    wr(6'h00, 8'h23);
    rd(6'h00, d); chk(d == 8'h23, "R7 clear flag", d, 8'h23);
    chk(eoc_irq == 0, "R6 irq drops", eoc_irq, 0);

    // R5 left alignment on same stored data
    wr(6'h02, 8'h02);
    chk_bufs(3, 0, "R5 left aligned buffers");

    // R9 continuous, then stop after pass
    log_n = 0;
    wr(6'h01, 8'h03);
    while (log_n < 9) @(posedge clk);
    wr(6'h01, 8'h01);
    wait_quiet(60, seen);
    chk(log_n % 4 == 0 && log_n >= 12, "R9 continuous full passes", log_n, 12);
    chk_order(0, 3, log_n / 4, "R9 restart at channel 0");

    // R8 last-channel rewrite mid pass
    wr(6'h00, 8'h07);
    log_n = 0;
    wr(6'h01, 8'h01);
    while (log_n < 3) @(posedge clk);
    wr(6'h00, 8'h01);
    wait_eoc("R8 flag after shortened pass");
    wait_quiet(30, seen);
    chk_order(0, 2, 1, "R8 pass ends at rewritten limit");
    rd(6'h00, d); chk(d[3:0] == 4'h1, "R8 field reloaded", d[3:0], 1);

    // R11 clamp
    wr(6'h00, 8'h0F);
    log_n = 0;
    wr(6'h01, 8'h01);
    wait_eoc("R11 flag after clamped pass");
    wait_quiet(30, seen);
    chk_order(0, NCH - 1, 1, "R11 clamp to top channel");
    rd(6'h00, d); chk(d[3:0] == 4'hF, "R11 raw field kept", d[3:0], 15);

    // R10 non-scan single channel
    wr(6'h02, 8'h08);
    wr(6'h00, 8'h05);
    log_n = 0;
    wr(6'h01, 8'h01);
    wait_eoc("R10 flag after single");
    wait_quiet(30, seen);
    chk_order(5, 5, 1, "R10 only the named channel");
    chk_bufs(5, 1, "R10 R4 buffer of channel 5");

    // R7 set wins over same-cycle clear
    wr(6'h00, 8'h05);
    manual = 1;
    wr(6'h01, 8'h01);
    while (!busy) @(posedge clk);
    @(posedge clk); #1 force_fire = 1;
    @(negedge clk); reg_wr = 1; reg_addr = 6'h00; reg_wdata = 8'h05;
    @(posedge clk); #1 force_fire = 0; manual = 0;
    @(negedge clk); reg_wr = 0;
    rd(6'h00, d); chk(d[7] == 1, "R7 set beats clear", d[7], 1);

    // R12 power-down abort
    wr(6'h02, 8'h0A);
    wr(6'h00, 8'h03);
    log_n = 0;
    wr(6'h01, 8'h03);
    while (log_n < 2) @(posedge clk);
    wr(6'h01, 8'h00);
    wait_quiet(30, seen);
    chk(seen == 0, "R12 request dropped", seen, 0);
    wr(6'h00, 8'h03);
    log_n = 0;
    wr(6'h01, 8'h01);
    wait_quiet(30, seen);
    chk(seen == 0 && log_n == 0, "R12 R2 rewake only", seen, 0);
    wr(6'h01, 8'h01);
    wait_eoc("R12 flag after restart");
    wait_quiet(30, seen);
    chk_order(0, 3, 1, "R12 restart order");
    chk_bufs(3, 1, "R12 R4 buffers after restart");

    // Random one-shot passes
    for (int it = 0; it < 8; it++) begin
      int lst = int'($urandom % NCH);
      bit ral = 1'($urandom % 2);
      wr(6'h02, {4'b0, ral, 3'b010});
      wr(6'h00, 8'(lst));
      log_n = 0;
      wr(6'h01, 8'h01);
      wait_eoc("R6 random pass flag");
      wait_quiet(20, seen);
      chk_order(0, lst, 1, "R3 random order");
      chk_bufs(lst, ral, "R4 R5 random buffers");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule